// File: doc/BRIEF.md
# IR pulse event normalizer

This block sits behind a run-length capture FIFO of an infrared receiver and turns its byte entries into clean pulse/space events. Each entry carries a line level in bit 7 and a sample-tick count in bits 6:0. Entries of equal level are summed into one run. When the level changes, the run is handed on as an event with a level and a duration in ticks, so a software or hardware bit decoder downstream sees each pulse and each space exactly once.

The first completed run of a frame is taken as the header and selects one of two protocols. A header close to sixteen pulse-distance units marks a pulse-distance frame; any other length marks a bi-phase frame. In a bi-phase frame, a run of about two half-bit cells is split into two equal events, which gives the decoder a uniform cell grid. A packet-end strobe flushes the last open run and is followed by a frame-done pulse. An overflow strobe discards the frame state without emitting anything.

Both unit lengths are parameters given in sample ticks: `PD_UNIT_TICKS` (default 9) and `BP_UNIT_TICKS` (default 14). Durations are `DUR_W` bits wide (default 12).

Top module: `ir_pulse_norm`

## Requirements
- R1: An entry is in_data[7] = level and in_data[6:0] = length in ticks. While a frame is open, entries of the same level add into one run. An entry of the other level emits the open run, with its level and total length, as one event and starts a new run.
- R2: The first entry after reset, after a flush or after an overflow opens a run and emits no event.
- R3: The first run that is closed in a frame is the header. proto_biphase becomes 0 if its length lies strictly between 14 and 18 pulse-distance units (127 to 161 ticks at defaults) and becomes 1 otherwise. The flag then holds until the next header.
- R4: The header event is emitted with its length unchanged, whichever protocol it selects.
- R5: In a bi-phase frame, a later closed run whose length is strictly between 1.5 and 2.5 bi-phase units (22 to 34 ticks at defaults) is emitted as two identical back-to-back events of floor(length/2). No entry is accepted until the second event has been taken.
- R6: All other closed runs are emitted unchanged. This covers bi-phase runs of exactly 21 or 35 ticks and any run in a pulse-distance frame.
- R7: A pkt_end pulse flushes an open run of non-zero length as a final event, unchanged and never split. It then clears the frame state, and no entry is accepted while the flush is pending.
- R8: frame_done pulses one cycle after the final flushed event is accepted. When no run was open, it pulses one cycle after the flush, and no event is produced.
- R9: A fifo_ovf pulse clears the frame state, emits nothing, and cancels a pkt_end that arrives in the same cycle.
- R10: While ev_valid is high and ev_ready is low, ev_level and ev_dur hold and in_ready is low.
- R11: A run's length saturates at 2^DUR_W-1 ticks.
- R12: After reset, ev_valid and frame_done are 0, proto_biphase is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Capture entry available |
| in_ready | output | 1 | Entry accepted on this edge when in_valid is high |
| in_data | input | 8 | Level in bit 7, tick count in bits 6:0 |
| pkt_end | input | 1 | Packet-end strobe |
| fifo_ovf | input | 1 | Capture overflow strobe |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Downstream takes the event |
| ev_level | output | 1 | Line level of the event |
| ev_dur | output | DUR_W | Event duration in ticks |
| proto_biphase | output | 1 | 1 = bi-phase frame, 0 = pulse-distance frame |
| frame_done | output | 1 | One-cycle pulse that ends a frame |

## Verification
Properties checked on every cycle: the output holds while stalled, the second beat of a split repeats the first, no event overwrites a pending one, no entry is taken during a flush, the protocol flag changes only when a header closes, and flush or overflow leaves the run and header state clear. The directed scenarios are needed for everything that depends on values. These are the header window edges (126, 127, 161 and 162 ticks), the split window edges and the halving of odd lengths, merging across many entries up to saturation, the exact cycle of frame_done, and the rule that an overflow drops a frame's open run without emitting it.

// File: rtl/ir_norm_pkg.sv
// Package: shared constants and types of the IR pulse event normalizer.
// Assumes capture entries are one byte: a level bit above a 7-bit tick count.
package ir_norm_pkg;
    localparam int ENT_W        = 8;
    localparam int LEN_W        = ENT_W - 1;
    localparam int HDR_UNITS    = 16;   // nominal header length in pulse-distance units
    localparam int HDR_TOL      = 2;    // header tolerance in the same units
    localparam int SPLIT_LO_X2  = 3;    // lower split bound, in half bi-phase units
    localparam int SPLIT_HI_X2  = 5;    // upper split bound, in half bi-phase units

    typedef enum logic {
        PROTO_PD = 1'b0,
        PROTO_BP = 1'b1
    } proto_e;
endpackage

// File: rtl/ir_run_acc.sv
// Module: ir_run_acc
// Merges same-level capture entries into one run and reports a run as closed
// when an entry of the other level arrives. Assumes take and clear never
// coincide; the top guarantees this.
module ir_run_acc
    import ir_norm_pkg::*;
#(
    parameter int DUR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             ent_lvl,
    input  logic [LEN_W-1:0] ent_len,
    input  logic             clear,
    output logic             closed,
    output logic             closed_lvl,
    output logic [DUR_W-1:0] closed_len,
    output logic             rcv,
    output logic [DUR_W-1:0] cur_len
);
    localparam logic [DUR_W-1:0] DUR_MAX = '1;

    logic             lvl_q;
    logic [DUR_W:0]   sum_w;
    logic [DUR_W-1:0] sum_sat;

    // Saturating addition of the new entry to the open run.
    always_comb begin
        sum_w   = {1'b0, cur_len} + (DUR_W+1)'(ent_len);
        sum_sat = sum_w[DUR_W] ? DUR_MAX : sum_w[DUR_W-1:0];
    end

    // A level change while a run is open closes that run.
    always_comb begin
        closed     = take && rcv && (ent_lvl != lvl_q);
        closed_lvl = lvl_q;
        closed_len = cur_len;
    end

    // Run state: open flag, level and accumulated length.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rcv     <= 1'b0;
            lvl_q   <= 1'b0;
            cur_len <= '0;
        end else if (take) begin
            if (!rcv || (ent_lvl != lvl_q)) begin
                rcv     <= 1'b1;
                lvl_q   <= ent_lvl;
                cur_len <= DUR_W'(ent_len);
            end else begin
                cur_len <= sum_sat;
            end
        end
    end

    // R2: an entry that opens a run closes nothing.
    a_r2_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !rcv) |-> !closed);
    // R9 / R7: a clear leaves no open run behind.
    a_r9_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!rcv && cur_len == '0));
endmodule

// File: rtl/ir_run_shape.sv
// Module: ir_run_shape
// Classifies the first closed run of a frame as the header and picks the
// protocol. In bi-phase frames it marks double-cell runs for splitting.
// Assumes the unit parameters are in sample ticks and DUR_W fits the header.
module ir_run_shape
    import ir_norm_pkg::*;
#(
    parameter int DUR_W         = 12,
    parameter int PD_UNIT_TICKS = 9,
    parameter int BP_UNIT_TICKS = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             closed,
    input  logic [DUR_W-1:0] len,
    input  logic             clear,
    output logic             hdr_seen,
    output logic             proto_bp,
    output logic             split,
    output logic [DUR_W-1:0] out_len
);
    localparam logic [31:0] HDR_LO = 32'((HDR_UNITS - HDR_TOL) * PD_UNIT_TICKS);
    localparam logic [31:0] HDR_HI = 32'((HDR_UNITS + HDR_TOL) * PD_UNIT_TICKS);
    localparam logic [31:0] SPL_LO = 32'(SPLIT_LO_X2 * BP_UNIT_TICKS);
    localparam logic [31:0] SPL_HI = 32'(SPLIT_HI_X2 * BP_UNIT_TICKS);

    logic [31:0] len32;
    logic [31:0] len_x2;
    logic        in_hdr_win;
    logic        in_spl_win;

    // Window tests; the split test compares doubled length to stay exact.
    always_comb begin
        len32      = 32'(len);
        len_x2     = len32 << 1;
        in_hdr_win = (len32 > HDR_LO) && (len32 < HDR_HI);
        in_spl_win = (len_x2 > SPL_LO) && (len_x2 < SPL_HI);
    end

    // Split decision and the length that goes out on the event port.
    always_comb begin
        split   = closed && hdr_seen && (proto_bp == PROTO_BP) && in_spl_win;
        out_len = split ? (len >> 1) : len;
    end

    // Header tracking and protocol selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_seen <= 1'b0;
            proto_bp <= PROTO_PD;
        end else if (clear) begin
            hdr_seen <= 1'b0;
        end else if (closed && !hdr_seen) begin
            hdr_seen <= 1'b1;
            proto_bp <= in_hdr_win ? PROTO_PD : PROTO_BP;
        end
    end

    // R3: the protocol flag moves only when a header closes.
    a_r3_proto_at_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(proto_bp) |-> $past(closed && !hdr_seen));
    // R7: a flush or overflow forgets the header.
    a_r7_hdr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !hdr_seen);
endmodule

// File: rtl/ir_evt_out.sv
// Module: ir_evt_out
// One-entry output register with valid/ready. It can replay its content once
// for a split run and raises frame_done after the last event of a frame.
// Assumes load is asserted only while slot_free is high.
module ir_evt_out #(
    parameter int DUR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             ld_lvl,
    input  logic [DUR_W-1:0] ld_dur,
    input  logic             ld_twice,
    input  logic             ld_last,
    input  logic             flush_empty,
    input  logic             ev_ready,
    output logic             ev_valid,
    output logic             ev_level,
    output logic [DUR_W-1:0] ev_dur,
    output logic             slot_free,
    output logic             frame_done
);
    logic rep_q;
    logic last_q;
    logic hs;

    // Handshake and the free-slot condition seen by the input side.
    always_comb begin
        hs        = ev_valid && ev_ready;
        slot_free = !ev_valid || (ev_ready && !rep_q);
    end

    // Output register with a one-time replay for split runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_valid <= 1'b0;
            ev_level <= 1'b0;
            ev_dur   <= '0;
            rep_q    <= 1'b0;
            last_q   <= 1'b0;
        end else if (load) begin
            ev_valid <= 1'b1;
            ev_level <= ld_lvl;
            ev_dur   <= ld_dur;
            rep_q    <= ld_twice;
            last_q   <= ld_last;
        end else if (hs) begin
            if (rep_q) begin
                rep_q <= 1'b0;
            end else begin
                ev_valid <= 1'b0;
                last_q   <= 1'b0;
            end
        end
    end

    // Frame-done pulse after the final event leaves or after an empty flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
        end else begin
            frame_done <= (hs && !rep_q && last_q) || flush_empty;
        end
    end

    // R10: a stalled event holds its content.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_level) && $stable(ev_dur)));
    // R5: the second beat of a split repeats the first.
    a_r5_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && rep_q) |=> (ev_valid && $stable(ev_level) && $stable(ev_dur)));
    // R10: nothing is loaded over a pending event.
    a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> slot_free);
endmodule

// File: rtl/ir_pulse_norm.sv
// Module: ir_pulse_norm (top)
// Turns run-length capture entries into normalized pulse/space events. Ties
// the run accumulator, header/split shaper and output register together and
// handles packet-end flush and overflow. Assumes pkt_end comes after the
// frame's last entry has been offered.
module ir_pulse_norm
    import ir_norm_pkg::*;
#(
    parameter int DUR_W         = 12,
    parameter int PD_UNIT_TICKS = 9,
    parameter int BP_UNIT_TICKS = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ENT_W-1:0] in_data,
    input  logic             pkt_end,
    input  logic             fifo_ovf,
    output logic             ev_valid,
    input  logic             ev_ready,
    output logic             ev_level,
    output logic [DUR_W-1:0] ev_dur,
    output logic             proto_biphase,
    output logic             frame_done
);
    logic             flush_req;
    logic             slot_free;
    logic             take;
    logic             flush_go;
    logic             flush_emit;
    logic             flush_empty;
    logic             clear;
    logic             closed;
    logic             closed_lvl;
    logic [DUR_W-1:0] closed_len;
    logic             rcv;
    logic [DUR_W-1:0] cur_len;
    logic             hdr_seen;
    logic             split;
    logic [DUR_W-1:0] shaped_len;
    logic             load;
    logic             ld_lvl;
    logic [DUR_W-1:0] ld_dur;

    // Input acceptance and flush scheduling.
    always_comb begin
        in_ready    = slot_free && !flush_req && !fifo_ovf;
        take        = in_valid && in_ready;
        flush_go    = flush_req && slot_free && !fifo_ovf;
        flush_emit  = flush_go && rcv && (cur_len != '0);
        flush_empty = flush_go && !flush_emit;
        clear       = flush_go || fifo_ovf;
    end

    // Event source: a closed run (possibly halved) or the flushed run.
    always_comb begin
        load   = closed || flush_emit;
        ld_lvl = closed_lvl;
        ld_dur = closed ? shaped_len : cur_len;
    end

    // Pending flush request; overflow cancels it.
    always_ff @(posedge clk) begin
        if (!rst_n || fifo_ovf) begin
            flush_req <= 1'b0;
        end else if (pkt_end) begin
            flush_req <= 1'b1;
        end else if (flush_go) begin
            flush_req <= 1'b0;
        end
    end

    ir_run_acc #(
        .DUR_W (DUR_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .ent_lvl    (in_data[ENT_W-1]),
        .ent_len    (in_data[LEN_W-1:0]),
        .clear      (clear),
        .closed     (closed),
        .closed_lvl (closed_lvl),
        .closed_len (closed_len),
        .rcv        (rcv),
        .cur_len    (cur_len)
    );

    ir_run_shape #(
        .DUR_W         (DUR_W),
        .PD_UNIT_TICKS (PD_UNIT_TICKS),
        .BP_UNIT_TICKS (BP_UNIT_TICKS)
    ) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .closed   (closed),
        .len      (closed_len),
        .clear    (clear),
        .hdr_seen (hdr_seen),
        .proto_bp (proto_biphase),
        .split    (split),
        .out_len  (shaped_len)
    );

    ir_evt_out #(
        .DUR_W (DUR_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .ld_lvl      (ld_lvl),
        .ld_dur      (ld_dur),
        .ld_twice    (split),
        .ld_last     (flush_emit),
        .flush_empty (flush_empty),
        .ev_ready    (ev_ready),
        .ev_valid    (ev_valid),
        .ev_level    (ev_level),
        .ev_dur      (ev_dur),
        .slot_free   (slot_free),
        .frame_done  (frame_done)
    );

    // R7: no entry is taken while a flush is pending.
    a_r7_no_take_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !in_ready);
    // R9: an overflow leaves no flush pending.
    a_r9_ovf_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ovf |=> !flush_req);
    // R12: reset state at the ports.
    a_r12_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!ev_valid && !frame_done && !proto_biphase));
endmodule

// File: tb/tb_ir_pulse_norm.sv
// Directed bench for ir_pulse_norm: one task per scenario, each checking itself.
module tb_ir_pulse_norm;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_data = '0;
    logic          pkt_end = 1'b0;
    logic          fifo_ovf = 1'b0;
    logic          ev_valid;
    logic          ev_ready = 1'b1;
    logic          ev_level;
    logic [DW-1:0] ev_dur;
    logic          proto_biphase;
    logic          frame_done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int n_ev = 0;
    int hs_cyc = -10;
    int fd_cnt = 0;
    int fd_cyc = -10;
    bit ev_l [64];
    int ev_d [64];

    ir_pulse_norm #(.DUR_W(DW), .PD_UNIT_TICKS(9), .BP_UNIT_TICKS(14)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .pkt_end(pkt_end), .fifo_ovf(fifo_ovf),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_level(ev_level),
        .ev_dur(ev_dur), .proto_biphase(proto_biphase), .frame_done(frame_done)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: records accepted events and frame_done pulses mid-cycle.
    always @(negedge clk) begin
        if (rst_n && ev_valid && ev_ready) begin
            if (n_ev < 64) begin
                ev_l[n_ev] = ev_level;
                ev_d[n_ev] = int'(ev_dur);
            end
            n_ev   = n_ev + 1;
            hs_cyc = cyc;
        end
        if (rst_n && frame_done) begin
            fd_cnt = fd_cnt + 1;
            fd_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic exp_ev(input int idx, input bit l, input int d, input string req);
        chk(idx < n_ev && idx < 64, req, n_ev, idx + 1);
        if (idx < n_ev && idx < 64)
            chk(ev_l[idx] == l && ev_d[idx] == d, req,
                int'(ev_l[idx]) * 65536 + ev_d[idx], int'(l) * 65536 + d);
    endtask

    task automatic send(input bit l, input int n);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_data  = {l, 7'(n)};
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic send_len(input bit l, input int total);
        int rest = total;
        while (rest > 0) begin
            send(l, (rest > 127) ? 127 : rest);
            rest = rest - ((rest > 127) ? 127 : rest);
        end
    endtask

    task automatic pulse(input bit do_end, input bit do_ovf);
        @(posedge clk); #1;
        pkt_end  = do_end;
        fifo_ovf = do_ovf;
        @(posedge clk); #1;
        pkt_end  = 1'b0;
        fifo_ovf = 1'b0;
    endtask

    // Flush and check the event count of the frame and frame_done timing.
    task automatic end_frame(input int base, input int n_exp);
        int fd0 = fd_cnt;
        pulse(1'b1, 1'b0);
        repeat (10) @(posedge clk);
        chk(n_ev - base == n_exp, "R7 event count", n_ev - base, n_exp);
        chk(fd_cnt == fd0 + 1, "R8 frame_done count", fd_cnt - fd0, 1);
        chk(fd_cyc == hs_cyc + 1, "R8 frame_done timing", fd_cyc - hs_cyc, 1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!ev_valid, "R12 ev_valid", int'(ev_valid), 0);
        chk(in_ready, "R12 in_ready", int'(in_ready), 1);
        chk(!proto_biphase, "R12 proto", int'(proto_biphase), 0);
        chk(!frame_done, "R12 frame_done", int'(frame_done), 0);
    endtask

    task automatic t_pulse_distance;
        int b = n_ev;
        send(1, 100);
        repeat (3) @(posedge clk);
        chk(n_ev == b, "R2 first entry silent", n_ev - b, 0);
        send(1, 40);
        send(0, 20);
        send(0, 10);
        send(1, 28);
        send(0, 15);
        end_frame(b, 4);
        exp_ev(b,     1, 140, "R4 header unchanged");
        exp_ev(b + 1, 0, 30,  "R6 no split in pulse-distance frame");
        exp_ev(b + 2, 1, 28,  "R1 merge and close");
        exp_ev(b + 3, 0, 15,  "R7 flushed run");
        chk(proto_biphase == 1'b0, "R3 140 ticks is pulse-distance", int'(proto_biphase), 0);
    endtask

    task automatic t_biphase;
        int b = n_ev;
        send(1, 60);
        send(0, 28);
        send(1, 21);
        send(0, 35);
        send(1, 9);
        send(0, 30);
        end_frame(b, 7);
        exp_ev(b,     1, 60, "R4 bi-phase header unchanged");
        exp_ev(b + 1, 0, 14, "R5 split first beat");
        exp_ev(b + 2, 0, 14, "R5 split second beat");
        exp_ev(b + 3, 1, 21, "R6 21 ticks not split");
        exp_ev(b + 4, 0, 35, "R6 35 ticks not split");
        exp_ev(b + 5, 1, 9,  "R6 short run unchanged");
        exp_ev(b + 6, 0, 30, "R7 flushed run never split");
        chk(proto_biphase == 1'b1, "R3 60 ticks is bi-phase", int'(proto_biphase), 1);
    endtask

    task automatic t_split_edges;
        int b = n_ev;
        send(1, 60);
        send(0, 22);
        send(1, 23);
        send(0, 34);
        send(1, 3);
        end_frame(b, 8);
        exp_ev(b + 1, 0, 11, "R5 22 ticks split");
        exp_ev(b + 2, 0, 11, "R5 22 ticks split repeat");
        exp_ev(b + 3, 1, 11, "R5 23 ticks halves down");
        exp_ev(b + 4, 1, 11, "R5 23 ticks repeat");
        exp_ev(b + 5, 0, 17, "R5 34 ticks split");
        exp_ev(b + 6, 0, 17, "R5 34 ticks repeat");
        exp_ev(b + 7, 1, 3,  "R7 flushed short run");
    endtask

    task automatic t_hdr_edge(input int h, input bit exp_bp);
        int b = n_ev;
        send_len(1, h);
        send(0, 5);
        end_frame(b, 2);
        exp_ev(b, 1, h, "R4 header edge unchanged");
        exp_ev(b + 1, 0, 5, "R7 header edge flush");
        chk(proto_biphase == exp_bp, $sformatf("R3 header %0d", h), int'(proto_biphase), int'(exp_bp));
    endtask

    task automatic t_overflow;
        int b = n_ev;
        int fd0;
        send(1, 60);
        send(0, 30);
        pulse(1'b0, 1'b1);
        send(0, 7);
        send(1, 9);
        end_frame(b, 3);
        exp_ev(b,     1, 60, "R9 header before overflow");
        exp_ev(b + 1, 0, 7,  "R9 fresh run after overflow");
        exp_ev(b + 2, 1, 9,  "R9 flushed after overflow");
        b   = n_ev;
        fd0 = fd_cnt;
        send(1, 12);
        pulse(1'b1, 1'b1);
        repeat (10) @(posedge clk);
        chk(n_ev == b, "R9 overflow cancels flush events", n_ev - b, 0);
        chk(fd_cnt == fd0, "R9 overflow cancels frame_done", fd_cnt - fd0, 0);
        pulse(1'b1, 1'b0);
        repeat (10) @(posedge clk);
        chk(n_ev == b, "R8 empty flush emits nothing", n_ev - b, 0);
        chk(fd_cnt == fd0 + 1, "R8 empty flush frame_done", fd_cnt - fd0, 1);
    endtask

    task automatic t_backpressure;
        int b = n_ev;
        @(posedge clk); #1;
        ev_ready = 1'b0;
        send(1, 60);
        send(0, 30);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_data  = {1'b1, 7'd5};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(ev_valid && ev_dur == 12'd60, "R10 event held", int'(ev_dur), 60);
            chk(!in_ready, "R10 input stalled", int'(in_ready), 0);
        end
        @(posedge clk); #1;
        ev_ready = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        end_frame(b, 4);
        exp_ev(b,     1, 60, "R10 held event delivered");
        exp_ev(b + 1, 0, 15, "R5 split after stall");
        exp_ev(b + 2, 0, 15, "R5 split repeat after stall");
        exp_ev(b + 3, 1, 5,  "R7 flush after stall");
    endtask

    task automatic t_saturate;
        int b = n_ev;
        for (int i = 0; i < 33; i++) send(1, 127);
        send(0, 1);
        end_frame(b, 2);
        exp_ev(b,     1, 4095, "R11 run saturates");
        exp_ev(b + 1, 0, 1,    "R1 run after saturation");
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_pulse_distance();
        t_biphase();
        t_split_edges();
        t_hdr_edge(126, 1'b1);
        t_hdr_edge(127, 1'b0);
        t_hdr_edge(161, 1'b0);
        t_hdr_edge(162, 1'b1);
        t_overflow();
        t_backpressure();
        t_saturate();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule